// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for every received Ethernet frame, whether the frame is kept or dropped. It does this from the destination address alone. The receive MAC streams the frame one byte per cycle. The filter captures the first six bytes, which form the destination address, and runs an IEEE 802.3 CRC-32 over them as they arrive. One cycle after the sixth byte it presents a registered verdict. That verdict stays valid and unchanged until the next start of frame, so the downstream frame store can commit or discard the frame at any point before then.

A single control word sets the filtering policy: a master enable, unconditional acceptance of broadcast, of multicast or of unicast frames, an exact match against one programmed station address, and lookups in a 512-bit hash table for multicast and for unicast frames. The hash table and the station address are not mapped directly. Software writes an index through the control word and then writes data words that land at that index. After each data write the index moves on by one, so the whole table and the station address can be loaded with one stream of writes.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the verdict valid output is 0 and every control flag is 0. A frame received in this state therefore gets a verdict of reject.
- R2: When the enable flag (control bit 31) is 0, every frame is rejected, whatever the other flags are set to.
- R3: A destination address of all ones is broadcast. It is accepted only when enable and the accept-all-broadcast flag (bit 30) are both set. The multicast flags and the multicast hash never apply to it.
- R4: An address that is not broadcast and whose first byte has bit 0 set is multicast. It is accepted when the accept-all-multicast flag (bit 29) is set. The unicast flags never accept it.
- R5: An address whose first byte has bit 0 clear is unicast. It is accepted when the accept-all-unicast flag (bit 28) is set.
- R6: When the perfect-match flag (bit 25) is set, a unicast frame is accepted if its six address bytes equal the station address. The station address is stored in two words: index 16 holds address bytes 0 to 3 in bits [7:0], [15:8], [23:16] and [31:24], and bits [7:0] and [15:8] of index 17 hold bytes 4 and 5.
- R7: The hash is bits [31:23] of the CRC register after the six address bytes. That register is reflected, uses polynomial 0xEDB88320, starts at all ones, takes each byte least significant bit first, and is not inverted at the end. The hash bits [8:5] select table word 0 to 15 and bits [4:0] select a bit in that word. A multicast frame is accepted when the multicast-hash flag (bit 27) is set and the selected bit is 1. A unicast frame is accepted the same way under the unicast-hash flag (bit 26).
- R8: A control write (select 0) loads the flags from bits [31:25] and the index from bits [4:0]. A data write (select 1) stores the word at the current index and then moves the index on by one, wrapping from 17 to 0. A data write while the index is 18 or above stores nothing and leaves the index unchanged.
- R9: The verdict becomes valid in the cycle after the sixth address byte is taken. It stays valid and stable while further payload bytes arrive, and it goes to 0 in the cycle after a start-of-frame byte.
- R10: A configuration write in the same cycle as the sixth address byte does not affect that frame's verdict; the verdict uses the configuration as it stood before the write. Writes made after the verdict is valid do not change the verdict being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control/index word, 1 selects the data word |
| cfg_wdata | input | 32 | Configuration write data |
| frm_sof | input | 1 | Marks the first byte of a frame, together with byte_vld |
| byte_vld | input | 1 | Receive byte valid |
| byte_data | input | 8 | Receive byte, in the order it was received |
| verdict_vld | output | 1 | Verdict valid from after the sixth address byte until the next frame starts |
| verdict_accept | output | 1 | 1 accepts the frame, 0 rejects it |

## Verification
A data write into the hash table can land in the same clock cycle as the sixth address byte, and that cycle is also the one in which the verdict is sampled. To provoke the collision, the bench points the index at the table word that holds the frame's hash bit and then clears that word with a write issued alongside the last address byte. It then checks two things. The frame's verdict must still be accept, which shows the pre-write table was used. A repeat of the same frame must be rejected, which shows the write did take effect. The bench also issues a control write that clears the enable while a verdict is being held, and checks that the held verdict does not change.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic en;
    logic bcast_all;
    logic mcast_all;
    logic ucast_all;
    logic mcast_hash;
    logic ucast_hash;
    logic perfect;
  } rxf_mode_t;

  localparam int unsigned MODE_W   = $bits(rxf_mode_t);
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  // One byte of reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int unsigned HASH_WORDS = 16,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned STA_WORDS  = 2,
  parameter int unsigned IDX_W      = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_wr,
  input  logic                             cfg_sel,
  input  logic [WORD_W-1:0]                cfg_wdata,
  output rxf_mode_t                        mode_o,
  output logic [IDX_W-1:0]                 idx_o,
  output logic [HASH_WORDS*WORD_W-1:0]     hash_tbl_o,
  output logic [STA_WORDS*WORD_W-1:0]      station_o
);

  localparam int unsigned TOTAL_WORDS = HASH_WORDS + STA_WORDS;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_WORDS - 1);

  rxf_mode_t        mode_q, mode_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             data_we;
  logic             idx_in_range;
  logic [WORD_W-1:0] word_q [TOTAL_WORDS];
  logic [TOTAL_WORDS*WORD_W-1:0] words_flat;
  logic             unused_wdata;

  assign data_we      = cfg_wr & cfg_sel;
  assign idx_in_range = (idx_q <= LAST_IDX);
  assign unused_wdata = ^cfg_wdata[WORD_W-MODE_W-1:IDX_W];

  always_comb begin
    mode_d = mode_q;
    idx_d  = idx_q;
    if (cfg_wr && !cfg_sel) begin
      mode_d = rxf_mode_t'(cfg_wdata[WORD_W-1 -: MODE_W]);
      idx_d  = cfg_wdata[IDX_W-1:0];
    end else if (data_we && idx_in_range) begin
      idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      idx_q  <= '0;
    end else if (cfg_wr) begin
      mode_q <= mode_d;
      idx_q  <= idx_d;
    end
  end

  for (genvar g = 0; g < TOTAL_WORDS; g++) begin : g_word
    logic word_we;
    assign word_we = data_we && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q[g] <= '0;
      else if (word_we) word_q[g] <= cfg_wdata;
    end
    assign words_flat[g*WORD_W +: WORD_W] = word_q[g];
  end

  assign mode_o     = mode_q;
  assign idx_o      = idx_q;
  assign hash_tbl_o = words_flat[HASH_WORDS*WORD_W-1:0];
  assign station_o  = words_flat[TOTAL_WORDS*WORD_W-1:HASH_WORDS*WORD_W];

endmodule

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_sof,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_data,
  output logic                    last_o,
  output logic [8*ADDR_BYTES-1:0] da_nxt_o,
  output logic [8*ADDR_BYTES-1:0] da_q_o,
  output logic [31:0]             crc_nxt_o
);

  localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0]  cnt_q, cnt_d, pos;
  logic [ADDR_W-1:0] da_q, da_d;
  logic [31:0]       crc_q, crc_d, crc_base;
  logic              take;

  assign pos      = frm_sof ? '0 : cnt_q;
  assign take     = byte_vld && (frm_sof || cnt_q < CNT_FULL);
  assign crc_base = frm_sof ? CRC_INIT : crc_q;

  always_comb begin
    cnt_d = frm_sof ? '0 : cnt_q;
    da_d  = da_q;
    crc_d = frm_sof ? CRC_INIT : crc_q;
    if (take) begin
      cnt_d = pos + 1'b1;
      da_d  = {da_q[ADDR_W-9:0], byte_data};
      crc_d = crc_step(crc_base, byte_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      da_q  <= '0;
      crc_q <= CRC_INIT;
    end else if (take || frm_sof) begin
      cnt_q <= cnt_d;
      da_q  <= da_d;
      crc_q <= crc_d;
    end
  end

  assign last_o    = take && (pos == CNT_W'(ADDR_BYTES - 1));
  assign da_nxt_o  = da_d;
  assign da_q_o    = da_q;
  assign crc_nxt_o = crc_d;

endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict
  import rxf_pkg::*;
#(
  parameter int unsigned HASH_WORDS = 16,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned STA_WORDS  = 2,
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frm_sof,
  input  logic                         last_i,
  input  logic [8*ADDR_BYTES-1:0]      da_i,
  input  logic [31:0]                  crc_i,
  input  rxf_mode_t                    mode_i,
  input  logic [HASH_WORDS*WORD_W-1:0] hash_tbl_i,
  input  logic [STA_WORDS*WORD_W-1:0]  station_i,
  output logic                         vld_o,
  output logic                         acc_o
);

  localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
  localparam int unsigned HASH_W = $clog2(HASH_WORDS * WORD_W);

  logic [HASH_W-1:0] hash;
  logic              tbl_hit, sta_hit, is_bcast, is_mcast;
  logic              acc_d, vld_d, acc_q, vld_q;
  logic              unused_bits;

  assign hash        = crc_i[31 -: HASH_W];
  assign tbl_hit     = hash_tbl_i[hash];
  assign is_bcast    = &da_i;
  assign is_mcast    = da_i[ADDR_W-8];
  assign unused_bits = ^{crc_i[31-HASH_W:0], station_i[STA_WORDS*WORD_W-1:ADDR_W]};

  always_comb begin
    sta_hit = 1'b1;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (da_i[ADDR_W-1-8*b -: 8] != station_i[8*b +: 8]) sta_hit = 1'b0;
    end
  end

  always_comb begin
    if (!mode_i.en)    acc_d = 1'b0;
    else if (is_bcast) acc_d = mode_i.bcast_all;
    else if (is_mcast) acc_d = mode_i.mcast_all | (mode_i.mcast_hash & tbl_hit);
    else               acc_d = mode_i.ucast_all | (mode_i.perfect & sta_hit)
                              | (mode_i.ucast_hash & tbl_hit);
    vld_d = last_i ? 1'b1 : (frm_sof ? 1'b0 : vld_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (last_i) acc_q <= acc_d;
    end
  end

  assign vld_o = vld_q;
  assign acc_o = acc_q;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned HASH_WORDS = 16,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              frm_sof,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  output logic              verdict_vld,
  output logic              verdict_accept
);

  localparam int unsigned ADDR_W    = 8 * ADDR_BYTES;
  localparam int unsigned STA_WORDS = (ADDR_W + WORD_W - 1) / WORD_W;
  localparam int unsigned IDX_W     = $clog2(HASH_WORDS + STA_WORDS);
  localparam int unsigned LAST_IDX  = HASH_WORDS + STA_WORDS - 1;

  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  rxf_mode_t                    mode_w;
  logic [IDX_W-1:0]             idx_w;
  logic [HASH_WORDS*WORD_W-1:0] hash_tbl_w;
  logic [STA_WORDS*WORD_W-1:0]  station_w;
  logic                         last_w;
  logic [ADDR_W-1:0]            da_nxt_w, da_q_w;
  logic [31:0]                  crc_nxt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rxf_cfg_regs #(
    .HASH_WORDS(HASH_WORDS), .WORD_W(WORD_W), .STA_WORDS(STA_WORDS), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mode_o(mode_w), .idx_o(idx_w),
    .hash_tbl_o(hash_tbl_w), .station_o(station_w)
  );

  rxf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .frm_sof(frm_sof), .byte_vld(byte_vld),
    .byte_data(byte_data), .last_o(last_w), .da_nxt_o(da_nxt_w),
    .da_q_o(da_q_w), .crc_nxt_o(crc_nxt_w)
  );

  rxf_verdict #(
    .HASH_WORDS(HASH_WORDS), .WORD_W(WORD_W), .STA_WORDS(STA_WORDS), .ADDR_BYTES(ADDR_BYTES)
  ) u_vrd (
    .clk(clk), .rst_n(rst_int_n), .frm_sof(frm_sof), .last_i(last_w),
    .da_i(da_nxt_w), .crc_i(crc_nxt_w), .mode_i(mode_w),
    .hash_tbl_i(hash_tbl_w), .station_i(station_w),
    .vld_o(verdict_vld), .acc_o(verdict_accept)
  );

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned LAST_IDX = 17,
  parameter int unsigned ADDR_W   = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              cfg_sel,
  input logic              frm_sof,
  input logic              verdict_vld,
  input logic              verdict_accept,
  input logic              mode_en,
  input logic              mode_bcast,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic [ADDR_W-1:0] da_q
);

  // R9
  sof_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_sof |=> !verdict_vld);

  // R9
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && $past(verdict_vld)) |-> $stable(verdict_accept));

  // R2
  disabled_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(verdict_vld) && !$past(mode_en)) |-> !verdict_accept);

  // R3
  bcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(verdict_vld) && (&da_q) && !$past(mode_bcast)) |-> !verdict_accept);

  // R8
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel && cfg_idx == IDX_W'(LAST_IDX)) |=> (cfg_idx == '0));

  // R8
  idx_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel && cfg_idx > IDX_W'(LAST_IDX)) |=> $stable(cfg_idx));

endmodule

bind rx_addr_filter rx_addr_filter_chk #(
  .IDX_W(IDX_W), .LAST_IDX(LAST_IDX), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .frm_sof(frm_sof), .verdict_vld(verdict_vld), .verdict_accept(verdict_accept),
  .mode_en(mode_w.en), .mode_bcast(mode_w.bcast_all), .cfg_idx(idx_w), .da_q(da_q_w)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {flags[6:0] (en,bc,mc,uc,hm,hu,pf), da[47:0], expected accept}
  localparam logic [55:0] VEC [NVEC] = '{
    {7'h3F, 48'hFFFF_FFFF_FFFF, 1'b0},
    {7'h3F, 48'h0211_2233_4455, 1'b0},
    {7'h60, 48'hFFFF_FFFF_FFFF, 1'b1},
    {7'h50, 48'hFFFF_FFFF_FFFF, 1'b0},
    {7'h50, 48'h0100_5E00_0001, 1'b1},
    {7'h48, 48'h0100_5E00_0001, 1'b0},
    {7'h48, 48'h00AA_BBCC_DDEE, 1'b1},
    {7'h41, 48'h0211_2233_4455, 1'b1},
    {7'h41, 48'h0211_2233_4454, 1'b0},
    {7'h60, 48'h00AA_BBCC_DDEE, 1'b0},
    {7'h41, 48'h0311_2233_4455, 1'b0},
    {7'h46, 48'h0100_5E00_0001, 1'b0}
  };

  logic        clk, rst_n, cfg_wr, cfg_sel, frm_sof, byte_vld;
  logic [31:0] cfg_wdata;
  logic [7:0]  byte_data;
  logic        verdict_vld, verdict_accept;
  int          n_tests, n_fail;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .frm_sof(frm_sof), .byte_vld(byte_vld),
    .byte_data(byte_data), .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [8:0] hash_of(input logic [47:0] da);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      fb = c[0] ^ da[47 - 8*(k/8) - 7 + (k%8)];
      c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB8_8320 : 32'h0);
    end
    return c[31:23];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_verdict(input string req, input logic exp_acc);
    check(req, {30'd0, verdict_vld, verdict_accept}, {30'd0, 1'b1, exp_acc});
  endtask

  task automatic wr_ctl(input logic [6:0] flags, input logic [4:0] idx);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = {flags, 20'd0, idx};
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Leaves the caller at the negedge after the sixth byte was taken.
  task automatic send_frame(input logic [47:0] da, input bit coll,
                            input logic cs, input logic [31:0] cd);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      frm_sof = (k == 0); byte_vld = 1'b1; byte_data = da[47-8*k -: 8];
      if (k == 5 && coll) begin
        cfg_wr = 1'b1; cfg_sel = cs; cfg_wdata = cd;
      end
    end
    @(negedge clk);
    frm_sof = 1'b0; byte_vld = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [8:0]  hm, hu, hz, hnz;
    logic [47:0] dm, du, dz, dnz;
    bit          got_z, got_nz;
    string       tag;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    frm_sof = 1'b0; byte_vld = 1'b0; byte_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state and default policy
    check("R1 verdict_vld after reset", {31'd0, verdict_vld}, 32'd0);
    send_frame(48'hFFFF_FFFF_FFFF, 0, 0, 0);
    chk_verdict("R1 default reject", 1'b0);

    // station 02:11:22:33:44:55 at index 16/17
    wr_ctl(7'h00, 5'd16);
    wr_data(32'h3322_1102);
    wr_data(32'h0000_5544);

    for (int i = 0; i < NVEC; i++) begin
      case (i)
        0, 1:     tag = "R2 vector";
        2, 3, 9:  tag = "R3 vector";
        4:        tag = "R4 vector";
        5, 6:     tag = "R5 vector";
        7, 8, 10: tag = "R6 vector";
        default:  tag = "R7 vector";
      endcase
      wr_ctl(VEC[i][55:49], 5'd0);
      send_frame(VEC[i][48:1], 0, 0, 0);
      chk_verdict($sformatf("%s %0d", tag, i), VEC[i][0]);
    end

    // R9: payload bytes do not disturb the held verdict; SOF clears it
    wr_ctl(7'h60, 5'd0);
    send_frame(48'hFFFF_FFFF_FFFF, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); byte_vld = 1'b1; byte_data = 8'h00;
    end
    @(negedge clk); byte_vld = 1'b0;
    chk_verdict("R9 held over payload", 1'b1);
    frm_sof = 1'b1; byte_vld = 1'b1; byte_data = 8'h00;
    @(negedge clk); frm_sof = 1'b0; byte_vld = 1'b0;
    check("R9 cleared after sof", {31'd0, verdict_vld}, 32'd0);

    // R7: multicast and unicast hash paths
    dm = 48'h0100_5E7F_0009; hm = hash_of(dm);
    wr_ctl(7'h44, {1'b0, hm[8:5]});
    wr_data(32'd1 << hm[4:0]);
    send_frame(dm, 0, 0, 0);
    chk_verdict("R7 mcast hash hit", 1'b1);
    wr_ctl(7'h42, 5'd0);
    send_frame(dm, 0, 0, 0);
    chk_verdict("R7 mcast ignores ucast hash", 1'b0);
    wr_ctl(7'h44, {1'b0, hm[8:5]});
    wr_data(32'd0);
    du = 48'h00AA_BBCC_DD01; hu = hash_of(du);
    wr_ctl(7'h42, {1'b0, hu[8:5]});
    wr_data(32'd1 << hu[4:0]);
    send_frame(du, 0, 0, 0);
    chk_verdict("R7 ucast hash hit", 1'b1);
    wr_ctl(7'h44, 5'd0);
    send_frame(du, 0, 0, 0);
    chk_verdict("R7 ucast ignores mcast hash", 1'b0);

    // R10: table write colliding with the sixth byte
    wr_ctl(7'h42, {1'b0, hu[8:5]});
    send_frame(du, 1, 1'b1, 32'd0);
    chk_verdict("R10 colliding write uses old table", 1'b1);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'd0;
    @(negedge clk); cfg_wr = 1'b0;
    chk_verdict("R10 later write keeps held verdict", 1'b1);
    wr_ctl(7'h42, 5'd0);
    send_frame(du, 0, 0, 0);
    chk_verdict("R10 write took effect afterwards", 1'b0);

    // R8: sequential load with auto-advance, wrap and out-of-range index
    got_z = 0; got_nz = 0; dz = '0; dnz = '0;
    for (int k = 0; k < 256; k++) begin
      logic [47:0] cand;
      cand = {40'h01_005E_0000, k[7:0]};
      if (!got_z && hash_of(cand)[8:5] == 4'd0) begin dz = cand; got_z = 1; end
      if (!got_nz && hash_of(cand)[8:5] != 4'd0) begin dnz = cand; got_nz = 1; end
    end
    check("R8 search found word-0 address", {31'd0, got_z}, 32'd1);
    hz = hash_of(dz); hnz = hash_of(dnz);
    wr_ctl(7'h41, 5'd0);
    for (int k = 0; k < 16; k++) wr_data(32'd0);
    wr_data(32'h0D0C_0B0A);
    wr_data(32'h0000_0F0E);
    send_frame(48'h0A0B_0C0D_0E0F, 0, 0, 0);
    chk_verdict("R8 station via auto-advance", 1'b1);
    wr_data(32'hFFFF_FFFF);
    wr_ctl(7'h44, 5'd20);
    send_frame(dz, 0, 0, 0);
    chk_verdict($sformatf("R8 wrap to word 0 (hash %0h)", hz), 1'b1);
    send_frame(dnz, 0, 0, 0);
    chk_verdict($sformatf("R8 other word untouched (hash %0h)", hnz), 1'b0);
    wr_data(32'hFFFF_FFFF);
    send_frame(dnz, 0, 0, 0);
    chk_verdict("R8 index 20 write dropped", 1'b0);
    wr_ctl(7'h41, 5'd20);
    send_frame(48'h0A0B_0C0D_0E0F, 0, 0, 0);
    chk_verdict("R8 station intact", 1'b1);

    finish_run();
  end

endmodule